// File: doc/BRIEF.md
# DS3 Nibble-Parallel Payload Serializer

This block turns a 4-bit payload stream from system-side equipment into a continuous DS3 serial bit stream. It runs on the line-rate bit clock and emits one bit per cycle. The frame is built from 56 groups. Each group is one overhead bit followed by 84 payload bits, so a frame is 4760 bit periods long and needs 1176 payload nibbles. Frames follow one another with no idle gap.

The nibble bus carries payload only. The block paces the source in two ways: a request strobe that is high in the cycle a nibble is sampled, and a gapped nibble clock. Most nibble periods last 4 line clocks. The one nibble period per group that contains the overhead bit is stretched to 5 line clocks. Overhead bit values are not computed here. They are taken from a side input in the cycle of each overhead slot. The block marks that slot on an output, and also marks the first overhead bit of every frame.

Top module: `ds3_nib_serializer`

## Requirements
- R1: While rst_ni is low, ser_o, nib_req_o, nib_clk_o, oh_slot_o and frame_start_o are all 0. After release, the first clock edge outputs frame bit 0, the first overhead slot of a frame.
- R2: oh_slot_o is high for exactly one cycle in every 85, on group bit 0. In that cycle ser_o equals oh_bit_i as sampled at the edge that produced it.
- R3: frame_start_o is high for one cycle in every 4760, together with the overhead slot of group 0. The next frame starts directly after bit 4759.
- R4: nib_req_o is high while the bit about to be sent is group bit 1, 5, 9, ..., 81, where bit 0 is the overhead bit. nib_i is sampled on the rising edge that ends such a cycle. nib_req_o is never high for an overhead position.
- R5: A sampled nibble appears on ser_o over the next four cycles of payload, bit 3 first and bit 0 last.
- R6: The spacing between requests is 4 cycles, or 5 cycles when it spans an overhead bit. Each frame has 1176 requests, and 56 of the spacings are 5 cycles long.
- R7: nib_clk_o is high during the first two payload bits of each nibble. It is low during the other two payload bits and during the overhead bit.
- R8: Values on nib_i while nib_req_o is low have no effect on ser_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Line-rate bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| nib_i | input | 4 | Payload nibble, bit 3 is sent first |
| oh_bit_i | input | 1 | Overhead bit value for the current overhead slot |
| nib_req_o | output | 1 | Nibble request; nib_i is sampled at the edge ending this cycle |
| nib_clk_o | output | 1 | Gapped nibble clock |
| ser_o | output | 1 | Serial DS3 bit |
| frame_start_o | output | 1 | First overhead bit of a frame |
| oh_slot_o | output | 1 | Overhead bit position |

## Verification
The assertions assume that the source presents a valid nibble in every cycle in which nib_req_o is high, and that oh_bit_i is stable around each clock edge. They make no assumption about nib_i outside request cycles. The stimulus drives new random values on nib_i and oh_bit_i on the falling edge of every cycle. It places random junk on nib_i in cycles with no request, so any use of unrequested data shows up on ser_o. The run covers two full frames, then a reset in the middle of a frame followed by a restart.

// File: rtl/ds3_nib_pkg.sv
package ds3_nib_pkg;
  localparam int unsigned DEF_PAY_PER_GRP = 84;
  localparam int unsigned DEF_GRPS        = 56;
  localparam int unsigned DEF_NIB_W       = 4;
endpackage

// File: rtl/ds3_pos_cnt.sv
module ds3_pos_cnt #(
  parameter int unsigned PAY_PER_GRP = 84,
  parameter int unsigned GRPS        = 56,
  localparam int unsigned BW = $clog2(PAY_PER_GRP + 1),
  localparam int unsigned GW = $clog2(GRPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [BW-1:0] bit_o,
  output logic [GW-1:0] grp_o
);
  logic [BW-1:0] bit_q;
  logic [GW-1:0] grp_q;
  logic          grp_end, frm_end;

  assign grp_end = (bit_q == BW'(PAY_PER_GRP));
  assign frm_end = grp_end && (grp_q == GW'(GRPS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= '0;
      grp_q <= '0;
    end else if (grp_end) begin
      bit_q <= '0;
      grp_q <= frm_end ? '0 : grp_q + GW'(1);
    end else begin
      bit_q <= bit_q + BW'(1);
    end
  end

  assign bit_o = bit_q;
  assign grp_o = grp_q;

  // R3: frame wraps back to bit 0 of group 0 with no gap
  a_r3_frame_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_end |=> (bit_q == '0 && grp_q == '0));
  a_r2_bit_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BW'(PAY_PER_GRP));
endmodule

// File: rtl/ds3_nib_pacer.sv
module ds3_nib_pacer #(
  parameter int unsigned PAY_PER_GRP = 84,
  parameter int unsigned NIB_W       = 4,
  localparam int unsigned BW = $clog2(PAY_PER_GRP + 1),
  localparam int unsigned LW = $clog2(NIB_W)
) (
  input  logic [BW-1:0] bit_i,
  output logic          req_o,
  output logic          clk_phase_o
);
  logic [BW-1:0] off;
  logic          pay;

  assign pay = (bit_i != '0);
  assign off = bit_i - BW'(1);
  // nibble boundary on every NIB_W-th payload bit of the group
  assign req_o       = pay && (off[LW-1:0] == '0);
  assign clk_phase_o = pay && (off[LW-1:0] < LW'(NIB_W / 2));
endmodule

// File: rtl/ds3_nib_shifter.sv
module ds3_nib_shifter #(
  parameter int unsigned NIB_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             oh_i,
  input  logic             oh_bit_i,
  input  logic [NIB_W-1:0] nib_i,
  output logic             ser_o
);
  logic [NIB_W-1:0] sh_q;
  logic             ser_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q  <= '0;
      ser_q <= 1'b0;
    end else if (load_i) begin
      ser_q <= nib_i[NIB_W-1];
      sh_q  <= {nib_i[NIB_W-2:0], 1'b0};
    end else if (oh_i) begin
      ser_q <= oh_bit_i;  // shift register holds across the overhead slot
    end else begin
      ser_q <= sh_q[NIB_W-1];
      sh_q  <= {sh_q[NIB_W-2:0], 1'b0};
    end
  end

  assign ser_o = ser_q;

  a_r5_msb_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (ser_o == $past(nib_i[NIB_W-1])));
  a_r4_load_not_oh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && oh_i));
endmodule

// File: rtl/ds3_nib_serializer.sv
module ds3_nib_serializer
  import ds3_nib_pkg::*;
#(
  parameter int unsigned PAY_PER_GRP = DEF_PAY_PER_GRP,
  parameter int unsigned GRPS        = DEF_GRPS,
  parameter int unsigned NIB_W       = DEF_NIB_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NIB_W-1:0] nib_i,
  input  logic             oh_bit_i,
  output logic             nib_req_o,
  output logic             nib_clk_o,
  output logic             ser_o,
  output logic             frame_start_o,
  output logic             oh_slot_o
);
  localparam int unsigned BW = $clog2(PAY_PER_GRP + 1);
  localparam int unsigned GW = $clog2(GRPS);

  logic [BW-1:0] bit_pos;
  logic [GW-1:0] grp_pos;
  logic          req, phase, is_oh;
  logic          oh_q, frm_q, nclk_q;

  ds3_pos_cnt #(.PAY_PER_GRP(PAY_PER_GRP), .GRPS(GRPS)) u_pos (
    .clk_i(clk_i), .rst_ni(rst_ni), .bit_o(bit_pos), .grp_o(grp_pos)
  );

  ds3_nib_pacer #(.PAY_PER_GRP(PAY_PER_GRP), .NIB_W(NIB_W)) u_pace (
    .bit_i(bit_pos), .req_o(req), .clk_phase_o(phase)
  );

  assign is_oh = (bit_pos == '0);

  ds3_nib_shifter #(.NIB_W(NIB_W)) u_shift (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(req), .oh_i(is_oh),
    .oh_bit_i(oh_bit_i), .nib_i(nib_i), .ser_o(ser_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      oh_q   <= 1'b0;
      frm_q  <= 1'b0;
      nclk_q <= 1'b0;
    end else begin
      oh_q   <= is_oh;
      frm_q  <= is_oh && (grp_pos == '0);
      nclk_q <= phase;
    end
  end

  assign nib_req_o     = req;
  assign nib_clk_o     = nclk_q;
  assign oh_slot_o     = oh_q;
  assign frame_start_o = frm_q;

  // checker state: cycles since the last request
  logic [3:0] gap_q;
  logic       seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (req) begin
      gap_q  <= 4'd1;
      seen_q <= 1'b1;
    end else if (gap_q != 4'hf) begin
      gap_q <= gap_q + 4'd1;
    end
  end

  a_r6_req_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req && seen_q) |-> (gap_q == 4'(NIB_W) || gap_q == 4'(NIB_W + 1)));
  a_r2_oh_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_slot_o |-> (ser_o == $past(oh_bit_i)));
  a_r3_start_on_oh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> oh_slot_o);
  a_r7_clk_low_on_oh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oh_slot_o |-> !nib_clk_o);
  a_r4_no_req_on_oh: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nib_req_o |-> !is_oh);
endmodule

// File: tb/ds3_nib_serializer_test.sv
module ds3_nib_serializer_test;
  localparam int FRM = 4760;
  localparam int GRP = 85;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] nib = '0;
  logic       oh_bit = 1'b0;
  logic       nib_req, nib_clk, ser, frm_st, oh_slot;

  ds3_nib_serializer uut (
    .clk_i(clk), .rst_ni(rst_n), .nib_i(nib), .oh_bit_i(oh_bit),
    .nib_req_o(nib_req), .nib_clk_o(nib_clk), .ser_o(ser),
    .frame_start_o(frm_st), .oh_slot_o(oh_slot)
  );

  always #10 clk = ~clk;

  int  errs = 0, checks = 0;
  bit  exp_q[$];
  bit  oh_cur;
  int  last_a, req_cnt, long_cnt;
  bit  seen;

  function automatic void chk(bit ok, string rq, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endfunction

  function automatic void summary();
    $display("  Result: errors=%0d of %0d checks", errs, checks);
  endfunction

  // driver: inputs for absolute position a (next edge)
  task automatic drive(int a);
    int  k = (a % FRM) % GRP;
    bit  er = (k != 0) && ((k - 1) % 4 == 0);
    logic [3:0] n;
    chk(nib_req == er, "R4 req timing", int'(nib_req), int'(er));
    oh_cur = 1'($urandom);
    oh_bit = oh_cur;
    n = 4'($urandom);
    nib = n;  // junk when no request (R8)
    if (nib_req) begin
      for (int i = 3; i >= 0; i--) exp_q.push_back(n[i]);
      if (seen) begin
        chk((a - last_a) == 4 || (a - last_a) == 5, "R6 spacing", a - last_a, 4);
        if (a - last_a == 5) long_cnt++;
      end
      seen = 1'b1;
      last_a = a;
      req_cnt++;
    end
  endtask

  // monitor: outputs after edge a
  task automatic monitor(int a);
    int k = (a % FRM) % GRP;
    bit ec = (k != 0) && ((k - 1) % 4 < 2);
    bit e;
    chk(oh_slot == (k == 0), "R2 oh slot", int'(oh_slot), int'(k == 0));
    chk(frm_st == (a % FRM == 0), "R3 frame start", int'(frm_st), int'(a % FRM == 0));
    chk(nib_clk == ec, "R7 nib clk", int'(nib_clk), int'(ec));
    if (k == 0) begin
      chk(ser == oh_cur, "R2 oh value", int'(ser), int'(oh_cur));
    end else if (exp_q.size() == 0) begin
      chk(1'b0, "R5 no nibble queued", int'(ser), -1);
    end else begin
      e = exp_q.pop_front();
      chk(ser == e, "R5/R8 payload bit", int'(ser), int'(e));
    end
    if (a % FRM == FRM - 1) begin
      chk(req_cnt == 1176, "R6 reqs per frame", req_cnt, 1176);
      chk(long_cnt == ((a < FRM) ? 55 : 56), "R6 long periods", long_cnt,
          (a < FRM) ? 55 : 56);
      req_cnt = 0;
      long_cnt = 0;
    end
  endtask

  task automatic reset_and_run(int n);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(ser == 0 && nib_req == 0 && nib_clk == 0 && oh_slot == 0 && frm_st == 0,
        "R1 reset outputs", int'({ser, nib_req, nib_clk, oh_slot, frm_st}), 0);
    exp_q.delete();
    seen = 1'b0; req_cnt = 0; long_cnt = 0; last_a = 0;
    repeat (2) @(negedge clk);
    drive(0);
    rst_n = 1'b1;
    for (int a = 0; a < n; a++) begin
      @(posedge clk);
      @(negedge clk);
      if (a == 0) chk(frm_st == 1'b1, "R1 first bit is frame bit 0", int'(frm_st), 1);
      monitor(a);
      drive(a + 1);
    end
  endtask

  initial begin
    reset_and_run(2 * FRM + 1000);
    reset_and_run(400);  // reset mid-frame, restart at bit 0 (R1)
    summary();
    $finish;
  end

  initial begin
    #(20 * 200000);
    errs++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    summary();
    $finish;
  end
endmodule